// File: doc/BRIEF.md
# Exception-Return Status Shifter

This block updates a 32-bit status word when a processor returns from an ordinary exception or from a non-maskable interrupt. The low part of the status word holds a stack of mode and flag groups, ten bits per level. A return pops one level: the low 28 bits move right by ten places. The two top bits are kept, and the two bits below them are cleared.

After the pop, the block looks at the user-mode flag of the level that is now current. If that flag is set, the current stack pointer is saved as the kernel stack pointer and the user stack pointer becomes the live one. The restore-enable flag of the level being left is read before the shift. When it is clear, the result gets the pending flag. A return from a non-maskable interrupt also always sets the NMI-mask flag.

The results are registered one cycle after the request. Between requests they hold their values. The block sits next to the special-register file, and the return sequencer drives it. The sequencer never raises both request kinds in the same cycle.

Top module: `exret_status_shifter`

## Requirements
- R1: One cycle after a request, status_out[17:0] equals status_in[27:10] of the request cycle, except where R5 or R6 set a flag bit.
- R2: One cycle after a request, status_out[31:30] equals status_in[31:30] of the request cycle.
- R3: One cycle after a request, status_out[29:18] is zero.
- R4: The user-mode flag is bit 8 of the popped word, which is bit 18 of status_in. If it is set, the next cycle shows sp_out = usp_in, ksp_out = sp_in and ksp_we = 1. If it is clear, the next cycle shows sp_out = sp_in and ksp_we = 0, and ksp_out keeps its value.
- R5: The restore-enable flag is status_in bit 8, sampled before the pop. If it is 0, status_out bit 7 (the pending flag) is set after either return. If it is 1, bit 7 is the popped value.
- R6: A return from NMI (rfn_valid) always sets status_out bit 9. An ordinary return (rfe_valid) leaves bit 9 at its popped value.
- R7: In a cycle with no request, status_out, sp_out and ksp_out hold their values and ksp_we is 0 on the next cycle.
- R8: After a synchronous reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rfe_valid | input | 1 | Request an ordinary exception return |
| rfn_valid | input | 1 | Request a return from NMI |
| status_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| usp_in | input | 32 | Saved user stack pointer |
| status_out | output | 32 | Status word after the return |
| sp_out | output | 32 | Stack pointer after the return |
| ksp_out | output | 32 | Kernel stack pointer to store |
| ksp_we | output | 1 | One-cycle write strobe for ksp_out |

## Verification
The only internal state is the output register stage, so any fault shows at the ports on the cycle after the request. The fault shows up in one of these ways:
- a misplaced shift or mask puts a wrong bit pattern in status_out;
- a flag read from the wrong level gives a wrong pending bit or stack-pointer swap;
- a register that fails to hold changes an output during idle cycles, or leaves a stale ksp_we pulse.

The bench therefore compares every output one cycle after each request and again after an idle cycle.

// File: rtl/exret_pkg.sv
package exret_pkg;
  typedef enum logic [1:0] {
    RET_NONE = 2'd0,
    RET_EXC  = 2'd1,
    RET_NMI  = 2'd2
  } ret_kind_e;

  function automatic ret_kind_e decode_ret(input logic exc, input logic nmi);
    if (nmi)      return RET_NMI;
    else if (exc) return RET_EXC;
    else          return RET_NONE;
  endfunction
endpackage

// File: rtl/exret_level_pop.sv
module exret_level_pop #(
  parameter int DATA_W  = 32,
  parameter int KEEP_W  = 2,
  parameter int GAP_W   = 2,
  parameter int LEVEL_W = 10
) (
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] word_out
);
  localparam int STACK_W = DATA_W - KEEP_W - GAP_W;
  localparam logic [DATA_W-1:0] ONES      = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] KEEP_MASK = ~(ONES >> KEEP_W);
  localparam logic [DATA_W-1:0] LOW_MASK  = ONES >> (DATA_W - STACK_W);

  logic [DATA_W-1:0] kept;
  logic [DATA_W-1:0] stacked;

  always_comb begin
    kept     = word_in & KEEP_MASK;
    stacked  = (word_in & LOW_MASK) >> LEVEL_W;
    word_out = kept | stacked;
  end
endmodule

// File: rtl/exret_flag_merge.sv
module exret_flag_merge #(
  parameter int DATA_W = 32,
  parameter int P_BIT  = 7,
  parameter int M_BIT  = 9
) (
  input  logic [DATA_W-1:0] popped,
  input  logic              restore_prev,
  input  logic              is_nmi,
  output logic [DATA_W-1:0] merged
);
  always_comb begin
    merged = popped;
    if (!restore_prev) merged[P_BIT] = 1'b1;
    if (is_nmi)        merged[M_BIT] = 1'b1;
  end
endmodule

// File: rtl/exret_sp_swap.sv
module exret_sp_swap #(
  parameter int ADDR_W = 32
) (
  input  logic              to_user,
  input  logic [ADDR_W-1:0] cur_sp,
  input  logic [ADDR_W-1:0] user_sp,
  output logic [ADDR_W-1:0] next_sp,
  output logic [ADDR_W-1:0] save_sp,
  output logic              save_en
);
  always_comb begin
    save_sp = cur_sp;
    save_en = to_user;
    next_sp = to_user ? user_sp : cur_sp;
  end
endmodule

// File: rtl/exret_status_shifter.sv
module exret_status_shifter #(
  parameter int DATA_W  = 32,
  parameter int KEEP_W  = 2,
  parameter int GAP_W   = 2,
  parameter int LEVEL_W = 10,
  parameter int U_BIT   = 8,
  parameter int P_BIT   = 7,
  parameter int R_BIT   = 8,
  parameter int M_BIT   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rfe_valid,
  input  logic              rfn_valid,
  input  logic [DATA_W-1:0] status_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] usp_in,
  output logic [DATA_W-1:0] status_out,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] ksp_out,
  output logic              ksp_we
);
  import exret_pkg::*;

  ret_kind_e         kind;
  logic [DATA_W-1:0] popped;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] sp_nxt;
  logic [DATA_W-1:0] ksp_nxt;
  logic              ksp_en;

  assign kind = decode_ret(rfe_valid, rfn_valid);

  exret_level_pop #(
    .DATA_W(DATA_W), .KEEP_W(KEEP_W), .GAP_W(GAP_W), .LEVEL_W(LEVEL_W)
  ) u_pop (
    .word_in (status_in),
    .word_out(popped)
  );

  exret_flag_merge #(
    .DATA_W(DATA_W), .P_BIT(P_BIT), .M_BIT(M_BIT)
  ) u_merge (
    .popped      (popped),
    .restore_prev(status_in[R_BIT]),
    .is_nmi      (kind == RET_NMI),
    .merged      (merged)
  );

  exret_sp_swap #(
    .ADDR_W(DATA_W)
  ) u_swap (
    .to_user(popped[U_BIT]),
    .cur_sp (sp_in),
    .user_sp(usp_in),
    .next_sp(sp_nxt),
    .save_sp(ksp_nxt),
    .save_en(ksp_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_out <= '0;
      sp_out     <= '0;
      ksp_out    <= '0;
      ksp_we     <= 1'b0;
    end else begin
      ksp_we <= 1'b0;
      if (kind != RET_NONE) begin
        status_out <= merged;
        sp_out     <= sp_nxt;
        if (ksp_en) begin
          ksp_out <= ksp_nxt;
          ksp_we  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/exret_status_shifter_chk.sv
module exret_status_shifter_chk #(
  parameter int DATA_W  = 32,
  parameter int KEEP_W  = 2,
  parameter int GAP_W   = 2,
  parameter int LEVEL_W = 10,
  parameter int U_BIT   = 8,
  parameter int P_BIT   = 7,
  parameter int R_BIT   = 8,
  parameter int M_BIT   = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              rfe_valid,
  input logic              rfn_valid,
  input logic [DATA_W-1:0] status_in,
  input logic [DATA_W-1:0] sp_in,
  input logic [DATA_W-1:0] usp_in,
  input logic [DATA_W-1:0] status_out,
  input logic [DATA_W-1:0] sp_out,
  input logic [DATA_W-1:0] ksp_out,
  input logic              ksp_we
);
  localparam int STACK_W = DATA_W - KEEP_W - GAP_W;
  localparam int UIN     = U_BIT + LEVEL_W;

  logic req;
  assign req = rfe_valid | rfn_valid;

  p_keep_top_r2: assert property (@(posedge clk) disable iff (rst)
    req |=> status_out[DATA_W-1 -: KEEP_W] == $past(status_in[DATA_W-1 -: KEEP_W]));

  p_clear_gap_r3: assert property (@(posedge clk) disable iff (rst)
    req |=> status_out[DATA_W-KEEP_W-1 : STACK_W-LEVEL_W] == '0);

  p_user_swap_r4: assert property (@(posedge clk) disable iff (rst)
    (req && status_in[UIN]) |=> (ksp_we && sp_out == $past(usp_in) && ksp_out == $past(sp_in)));

  p_kernel_stay_r4: assert property (@(posedge clk) disable iff (rst)
    (req && !status_in[UIN]) |=> (!ksp_we && sp_out == $past(sp_in) && $stable(ksp_out)));

  p_pending_r5: assert property (@(posedge clk) disable iff (rst)
    (req && !status_in[R_BIT]) |=> status_out[P_BIT]);

  p_nmi_mask_r6: assert property (@(posedge clk) disable iff (rst)
    rfn_valid |=> status_out[M_BIT]);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !req |=> ($stable(status_out) && $stable(sp_out) && $stable(ksp_out) && !ksp_we));
endmodule

bind exret_status_shifter exret_status_shifter_chk #(
  .DATA_W(DATA_W), .KEEP_W(KEEP_W), .GAP_W(GAP_W), .LEVEL_W(LEVEL_W),
  .U_BIT(U_BIT), .P_BIT(P_BIT), .R_BIT(R_BIT), .M_BIT(M_BIT)
) u_chk (.*);

// File: tb/exret_status_shifter_tb.sv
module exret_status_shifter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        rfe_valid, rfn_valid;
  logic [31:0] status_in, sp_in, usp_in;
  logic [31:0] status_out, sp_out, ksp_out;
  logic        ksp_we;

  int checks = 0;
  int errors = 0;

  logic [31:0] ksp_model = 32'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exret_status_shifter u_dut (
    .clk(clk), .rst(rst), .rfe_valid(rfe_valid), .rfn_valid(rfn_valid),
    .status_in(status_in), .sp_in(sp_in), .usp_in(usp_in),
    .status_out(status_out), .sp_out(sp_out), .ksp_out(ksp_out), .ksp_we(ksp_we)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_status(input logic [31:0] s, input logic nmi);
    logic [31:0] r;
    r = (s & 32'hC000_0000) | ((s & 32'h0FFF_FFFF) >> 10);
    if (!s[8]) r = r | 32'h0000_0080;
    if (nmi)   r = r | 32'h0000_0200;
    return r;
  endfunction

  // One return request followed by an idle cycle; checks R1..R7.
  task automatic do_return(input logic nmi, input logic [31:0] s,
                           input logic [31:0] sp, input logic [31:0] usp);
    logic        user;
    logic [31:0] exp_st, exp_sp;
    user   = s[18];
    exp_st = model_status(s, nmi);
    exp_sp = user ? usp : sp;
    if (user) ksp_model = sp;
    @(negedge clk);
    rfe_valid = !nmi; rfn_valid = nmi;
    status_in = s; sp_in = sp; usp_in = usp;
    @(negedge clk);
    rfe_valid = 1'b0; rfn_valid = 1'b0;
    status_in = 32'hA5A5_5A5A; sp_in = 32'h1111_2222; usp_in = 32'h3333_4444;
    chk("R1 R2 R3 R5 R6 status", status_out, exp_st);
    chk("R4 sp_out", sp_out, exp_sp);
    chk("R4 ksp_we", {31'b0, ksp_we}, {31'b0, user});
    chk("R4 ksp_out", ksp_out, ksp_model);
    @(negedge clk);
    chk("R7 hold status", status_out, exp_st);
    chk("R7 hold sp", sp_out, exp_sp);
    chk("R7 hold ksp", ksp_out, ksp_model);
    chk("R7 strobe low", {31'b0, ksp_we}, 32'h0);
  endtask

  initial begin
    rst = 1'b1; rfe_valid = 1'b0; rfn_valid = 1'b0;
    status_in = '0; sp_in = '0; usp_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset status", status_out, 32'h0);
    chk("R8 reset sp", sp_out, 32'h0);
    chk("R8 reset ksp", ksp_out, 32'h0);
    chk("R8 reset strobe", {31'b0, ksp_we}, 32'h0);

    // R5: kernel-mode pop, restore flag clear -> pending set, no swap
    do_return(1'b0, 32'h0012_3400, 32'h0000_1000, 32'h0000_2000);
    // R4: user mode in popped level, restore flag set -> swap, no forced pending
    do_return(1'b0, 32'h0004_0100, 32'h0000_3000, 32'h0000_4000);
    // R6: NMI return sets mask flag
    do_return(1'b1, 32'h4000_0C00, 32'h0000_5000, 32'h0000_6000);
    // R2 R3: all ones, top kept, gap cleared, user swap
    do_return(1'b0, 32'hFFFF_FFFF, 32'hDEAD_0000, 32'hBEEF_0000);
    // R3 R6: only gap and restore bits, NMI
    do_return(1'b1, 32'h3000_0100, 32'h0000_7000, 32'h0000_8000);
    // R1: mixed pattern, NMI, user
    do_return(1'b1, 32'h8A5C_3DE6, 32'h1234_5678, 32'h8765_4321);
    // R6: ordinary return keeps popped bit 9 (status_in bit 19 = 0)
    do_return(1'b0, 32'h0000_0000, 32'h0000_9000, 32'h0000_A000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule